// File: doc/BRIEF.md
# Relay Output and Filtered Input Port

This block sits on a byte-wide host I/O bus and gives software control of eight relay drive lines and a view of eight isolated digital inputs. It answers a window of four consecutive bus addresses. The window's base comes from an external switch input. Inside the window, software can write and read back the relay latch, read the current input states, and choose for each channel whether its input is debounced by a slow filter or passed through with only synchronisation.

The slow filter lets an input fed from rectified AC read as a steady level, with no chatter at twice the mains frequency. A bypassed channel follows its pin within a few clock cycles. Because the relay latch reads back, software can change one relay with a read-modify-write and needs no shadow copy. The filter period is derived from the clock rate, so the same code serves any clock.

Top module: `relay_input_port`

## Requirements
- R1: The block responds only when addr[ADDR_W-1:2] equals base_sw. addr[1:0] selects the register. A write outside the window changes nothing. A read outside the window returns 0.
- R2: Offset 0 is the relay latch. A write updates relay_out at the next clock edge. Bit n drives relay n, and 1 means energised. A read of offset 0 returns the value last written.
- R3: Offset 1 returns the reported input states, with bit n for channel n and 1 meaning asserted. A write to offset 1 has no effect on any register or output.
- R4: Offset 2 is the filter-enable register, read/write, with bit n set enabling the slow filter on channel n. Offset 3 always reads 0 and ignores writes.
- R5: rdata is registered. It is loaded at the clock edge where rd_en is high and holds its value otherwise.
- R6: A read and a write to the same register in the same cycle return the contents from before the write. The write still takes effect.
- R7: With its filter bypassed, a channel passes through a two-flop synchroniser. A pin change shows in the reported state after the third clock edge.
- R8: With its filter enabled, a channel changes its reported state only after its synchronised input has differed from that state for FILT_CYCLES consecutive cycles, where FILT_CYCLES = CLK_HZ*FILT_US/1e6.
- R9: Any return of the input to the reported state restarts the filter count. An asserted input with periodic dropouts shorter than the filter period stays reported as asserted.
- R10: Reset clears the relay latch, the filter enables and the reported input states.
- R11: Each channel's filter choice is independent. Channels that share an input pattern but differ in enable report different timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and filter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_sw | input | ADDR_W-2 | Switch-selected window base (address bits above offset) |
| addr | input | ADDR_W | Bus address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wdata | input | NCH | Write data |
| rdata | output | NCH | Registered read data |
| in_raw | input | NCH | Raw isolated inputs, asynchronous |
| relay_out | output | NCH | Relay drive, 1 energises |

## Verification
A bus read and a bus write can hit the same register in the same clock cycle. The bench provokes this by raising both strobes at offset 0 and at offset 2 with new data. It judges the result by checking that the returned byte is the prior content and that a following read shows the new value. A filter state update can also land in the cycle in which its input register is being read. The bench reads offset 1 repeatedly around the expected update edge and checks both sides of the boundary with margins.

// File: rtl/rip_pkg.sv
package rip_pkg;

  typedef enum logic [1:0] {
    OFF_RELAY = 2'd0,
    OFF_INPUT = 2'd1,
    OFF_FEN   = 2'd2,
    OFF_SPARE = 2'd3
  } rip_off_e;

  // Clock cycles in a filter period of the given microseconds, at least one.
  function automatic int unsigned filt_cycles(longint unsigned clk_hz,
                                              longint unsigned period_us);
    longint unsigned c;
    c = (clk_hz * period_us) / 64'd1_000_000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

  // Width of a counter that must reach value n.
  function automatic int unsigned cnt_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/rip_decode.sv
module rip_decode
  import rip_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-3:0] base_sw,
  input  logic              wr_en,
  output logic              hit,
  output rip_off_e          off,
  output logic              wr_relay,
  output logic              wr_fen
);
  always_comb begin
    hit      = (addr[ADDR_W-1:2] == base_sw);
    off      = rip_off_e'(addr[1:0]);
    wr_relay = wr_en && hit && (off == OFF_RELAY);
    wr_fen   = wr_en && hit && (off == OFF_FEN);
  end
endmodule

// File: rtl/rip_sync.sv
module rip_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/rip_filter.sv
module rip_filter
  import rip_pkg::*;
#(
  parameter int unsigned CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic state,
  output logic load
);
  localparam int unsigned CW = cnt_width(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          differ;

  always_comb begin
    differ = (din != state);
    load   = en && differ && (cnt == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= 1'b0;
      cnt   <= '0;
    end else if (!en) begin
      state <= din;
      cnt   <= '0;
    end else if (!differ) begin
      cnt   <= '0;
    end else if (load) begin
      state <= din;
      cnt   <= '0;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/relay_input_port.sv
module relay_input_port
  import rip_pkg::*;
#(
  parameter int              ADDR_W  = 10,
  parameter int              NCH     = 8,
  parameter longint unsigned CLK_HZ  = 200_000_000,
  parameter longint unsigned FILT_US = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-3:0] base_sw,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [NCH-1:0]    wdata,
  output logic [NCH-1:0]    rdata,
  input  logic [NCH-1:0]    in_raw,
  output logic [NCH-1:0]    relay_out
);
  localparam int unsigned FILT_CYCLES = filt_cycles(CLK_HZ, FILT_US);

  logic           hit;
  rip_off_e       off;
  logic           wr_relay;
  logic           wr_fen;
  logic [NCH-1:0] relay_q;
  logic [NCH-1:0] fen_q;
  logic [NCH-1:0] sync_q;
  logic [NCH-1:0] in_state;
  logic [NCH-1:0] flt_load;
  logic [NCH-1:0] rd_val;

  rip_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .base_sw(base_sw), .wr_en(wr_en),
    .hit(hit), .off(off), .wr_relay(wr_relay), .wr_fen(wr_fen)
  );

  rip_sync #(.W(NCH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(in_raw), .q(sync_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    rip_filter #(.CYCLES(FILT_CYCLES)) u_flt (
      .clk(clk), .rst_n(rst_n), .en(fen_q[i]), .din(sync_q[i]),
      .state(in_state[i]), .load(flt_load[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      relay_q <= '0;
      fen_q   <= '0;
    end else begin
      if (wr_relay) relay_q <= wdata;
      if (wr_fen)   fen_q   <= wdata;
    end
  end

  always_comb begin
    unique case (off)
      OFF_RELAY: rd_val = relay_q;
      OFF_INPUT: rd_val = in_state;
      OFF_FEN:   rd_val = fen_q;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= hit ? rd_val : '0;
  end

  assign relay_out = relay_q;
endmodule

// File: rtl/rip_checker.sv
module rip_checker #(
  parameter int ADDR_W = 10,
  parameter int NCH    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NCH-1:0]    wdata,
  input logic [NCH-1:0]    rdata,
  input logic [NCH-1:0]    relay_out,
  input logic              hit,
  input logic [NCH-1:0]    fen_q,
  input logic [NCH-1:0]    sync_q,
  input logic [NCH-1:0]    in_state
);
  // R2: a write at offset 0 lands on the relay pins next cycle
  a_r2_relay_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit && addr[1:0] == 2'd0) |=> relay_out == $past(wdata));

  // R1 / R3 / R4: relays move only on an in-window write to offset 0
  a_r3_relay_only_off0: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && hit && addr[1:0] == 2'd0) |=> $stable(relay_out));

  // R1: reads outside the window return zero
  a_r1_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |=> rdata == '0);

  // R4: offset 3 reads zero
  a_r4_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit && addr[1:0] == 2'd3) |=> rdata == '0);

  // R5: rdata holds without a read strobe
  a_r5_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  // R8: an enabled channel changes only after its input differed
  a_r8_change_needs_differ: assert property (@(posedge clk) disable iff (!rst_n)
    (((in_state ^ $past(in_state)) & $past(fen_q)
      & ~($past(sync_q) ^ $past(in_state))) == '0));

  // R10: reset leaves all relays released
  a_r10_reset_clear: assert property (@(posedge clk)
    !rst_n |=> relay_out == '0);
endmodule

bind relay_input_port rip_checker #(.ADDR_W(ADDR_W), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .relay_out(relay_out), .hit(hit),
  .fen_q(fen_q), .sync_q(sync_q), .in_state(in_state)
);

// File: tb/tb_relay_input_port.sv
module tb_relay_input_port;
  localparam int              ADDR_W = 10;
  localparam int              NCH    = 8;
  localparam longint unsigned CLK_HZ = 2_000_000;
  localparam int              FILT   = 10000; // 2 MHz * 5000 us / 1e6
  localparam logic [ADDR_W-1:0] BASE = 10'h300;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-3:0] base_sw = BASE[ADDR_W-1:2];
  logic [ADDR_W-1:0] addr = '0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [NCH-1:0]    wdata = '0;
  logic [NCH-1:0]    rdata;
  logic [NCH-1:0]    in_raw = '0;
  logic [NCH-1:0]    relay_out;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  relay_input_port #(.ADDR_W(ADDR_W), .NCH(NCH), .CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rst_n(rst_n), .base_sw(base_sw), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .in_raw(in_raw), .relay_out(relay_out)
  );

  task automatic check(string req, logic [NCH-1:0] act, logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(logic [ADDR_W-1:0] a, logic [NCH-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(logic [ADDR_W-1:0] a, output logic [NCH-1:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic t_reset_state();
    logic [NCH-1:0] d;
    check("R10 relay_out after reset", relay_out, 8'h00);
    bus_rd(BASE + 0, d); check("R10 relay latch reads zero", d, 8'h00);
    bus_rd(BASE + 1, d); check("R10 inputs read zero", d, 8'h00);
    bus_rd(BASE + 2, d); check("R10 filter enables zero", d, 8'h00);
  endtask

  task automatic t_relay_rw();
    logic [NCH-1:0] d;
    bus_wr(BASE + 0, 8'h81);
    check("R2 relay_out bit7 and bit0", relay_out, 8'h81);
    bus_rd(BASE + 0, d); check("R2 relay readback", d, 8'h81);
    bus_wr(BASE + 0, 8'h5A);
    check("R2 relay_out second pattern", relay_out, 8'h5A);
    bus_rd(BASE + 0, d); check("R2 readback second pattern", d, 8'h5A);
    cyc(3);
    check("R5 rdata holds without read", rdata, 8'h5A);
  endtask

  task automatic t_readonly_and_spare();
    logic [NCH-1:0] d;
    bus_wr(BASE + 1, 8'hFF);
    check("R3 input write leaves relays", relay_out, 8'h5A);
    bus_rd(BASE + 1, d); check("R3 input write ignored", d, 8'h00);
    bus_rd(BASE + 2, d); check("R3 input write leaves enables", d, 8'h00);
    bus_wr(BASE + 2, 8'hC3);
    bus_rd(BASE + 2, d); check("R4 filter enable readback", d, 8'hC3);
    bus_wr(BASE + 2, 8'h00);
    bus_wr(BASE + 3, 8'hFF);
    bus_rd(BASE + 3, d); check("R4 offset 3 reads zero", d, 8'h00);
    check("R4 offset 3 write leaves relays", relay_out, 8'h5A);
    bus_rd(BASE + 2, d); check("R4 offset 3 write leaves enables", d, 8'h00);
  endtask

  task automatic t_window();
    logic [NCH-1:0] d;
    bus_wr(BASE + 4, 8'hFF);
    check("R1 write above window ignored", relay_out, 8'h5A);
    bus_wr(BASE - 4, 8'h00);
    check("R1 write below window ignored", relay_out, 8'h5A);
    bus_rd(BASE - 1, d); check("R1 read outside window is zero", d, 8'h00);
    base_sw = 8'h10;
    bus_wr(10'h040, 8'h0F);
    check("R1 moved base accepts write", relay_out, 8'h0F);
    bus_rd(BASE, d); check("R1 old base no longer answers", d, 8'h00);
    base_sw = BASE[ADDR_W-1:2];
  endtask

  task automatic t_same_cycle();
    logic [NCH-1:0] d;
    bus_wr(BASE + 0, 8'hA5);
    addr = BASE + 0; wdata = 8'h3C; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R6 same-cycle read returns old relay", rdata, 8'hA5);
    check("R6 same-cycle write still lands", relay_out, 8'h3C);
    addr = BASE + 2; wdata = 8'h11; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R6 same-cycle read returns old enables", rdata, 8'h00);
    bus_rd(BASE + 2, d); check("R6 enable write landed", d, 8'h11);
    bus_wr(BASE + 2, 8'h00);
  endtask

  task automatic t_bypass();
    logic [NCH-1:0] d;
    in_raw = 8'h96;
    cyc(3);
    bus_rd(BASE + 1, d); check("R7 bypass reported after three edges", d, 8'h96);
    in_raw = 8'h00;
    cyc(3);
    bus_rd(BASE + 1, d); check("R7 bypass falls after three edges", d, 8'h00);
  endtask

  task automatic t_filter();
    logic [NCH-1:0] d;
    bus_wr(BASE + 2, 8'h01);
    in_raw = 8'h01;
    cyc(FILT - 10);
    bus_rd(BASE + 1, d); check("R8 enabled filter still low before period", d, 8'h00);
    cyc(20);
    bus_rd(BASE + 1, d); check("R8 enabled filter high after period", d, 8'h01);
    in_raw = 8'h00;
    cyc(FILT / 2);
    in_raw = 8'h01;
    cyc(FILT / 2 + 100);
    bus_rd(BASE + 1, d); check("R9 short drop restarts count", d, 8'h01);
    in_raw = 8'h00;
    cyc(FILT + 20);
    bus_rd(BASE + 1, d); check("R8 enabled filter falls after period", d, 8'h00);
  endtask

  task automatic t_ripple();
    logic [NCH-1:0] d;
    bus_wr(BASE + 2, 8'h02);
    in_raw = 8'h06;
    cyc(FILT + 20);
    bus_rd(BASE + 1, d); check("R9 ripple channels settle high", d, 8'h06);
    for (int p = 0; p < 12; p++) begin
      in_raw = 8'h00;
      cyc(200);
      bus_rd(BASE + 1, d);
      check("R9 filtered stays high, bypassed drops in dip", d, 8'h02);
      cyc(100);
      in_raw = 8'h06;
      cyc(700);
    end
    in_raw = 8'h00;
    bus_wr(BASE + 2, 8'h00);
    cyc(5);
  endtask

  task automatic t_independent();
    logic [NCH-1:0] d;
    bus_wr(BASE + 2, 8'h08);
    in_raw = 8'h18;
    cyc(5);
    bus_rd(BASE + 1, d); check("R11 only bypassed channel follows", d, 8'h10);
    cyc(FILT + 20);
    bus_rd(BASE + 1, d); check("R11 filtered channel catches up", d, 8'h18);
  endtask

  task automatic t_reset_clear();
    logic [NCH-1:0] d;
    bus_wr(BASE + 0, 8'hFF);
    do_reset();
    check("R10 reset releases relays", relay_out, 8'h00);
    bus_rd(BASE + 2, d); check("R10 reset clears enables", d, 8'h00);
    in_raw = 8'h00;
    cyc(4);
    bus_rd(BASE + 1, d); check("R10 inputs low after reset", d, 8'h00);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(2);
    do_reset();
    t_reset_state();
    t_relay_rw();
    t_readonly_and_spare();
    t_window();
    t_same_cycle();
    t_bypass();
    t_filter();
    t_ripple();
    t_independent();
    t_reset_clear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule